// File: doc/BRIEF.md
# Character Blink Attribute Timer

This block decides, for each character drawn on an on-screen display, whether that character is shown or hidden at the present moment. A field-rate tick pulse drives an internal phase counter. A 3-bit control field chooses the blink period and what fraction of that period a blinking character stays on screen. Only characters whose per-character blink attribute is set are ever hidden. All others are always shown.

The control field is sampled only at a period boundary. A host can therefore rewrite it at any time without cutting a blink cycle short. The two period lengths, given in ticks, are parameters. The defaults (30 and 60 ticks) give half-second and one-second periods from a 60 Hz field tick. The visible span of a period is the period length times the duty fraction, rounded down.

Top module: `blink_attr_timer`

## Requirements
- R1: When `char_blink` is 0, `char_visible` is 1 in every cycle, whatever the phase or the control field.
- R2: Duty code 00 (`blink_ctrl[1:0]`) disables blinking: `char_visible` is 1 even with `char_blink` set, and the phase stays at 0.
- R3: Duty code 01: a blinking character is visible for the first floor(P/4) ticks of each period of P ticks and hidden for the rest.
- R4: Duty code 10: a blinking character is visible for the first floor(P/2) ticks of each period and hidden for the rest.
- R5: Duty code 11: a blinking character is visible for the first floor(3P/4) ticks of each period and hidden for the rest.
- R6: `blink_ctrl[2]` = 0 selects a period of SHORT_TICKS (default 30) ticks; 1 selects LONG_TICKS (default 60) ticks.
- R7: The phase advances by one on each cycle with `tick` high. It wraps to 0 after the last tick of a period, and it does not change on cycles without `tick`.
- R8: A new `blink_ctrl` value takes effect only at the next period boundary, the tick that wraps the phase. While the active duty is off, every tick counts as a boundary.
- R9: After reset the active control is all zeros (blinking off, short period) and the phase is 0, so every character is visible until a tick loads a new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle field-rate pulse |
| blink_ctrl | input | 3 | [2] period select, [1:0] duty code |
| char_blink | input | 1 | Blink attribute of the current character |
| char_visible | output | 1 | 1 = draw the character, 0 = hide it |

## Verification
The bench walks every period and duty combination across two full periods. This catches an off-by-one on a duty threshold or on the wrap point, which would show as one extra or one missing visible tick, or as a period one tick long. A control change made in the middle of a period is checked to leave the old pattern in place until the wrap. A design that loads immediately would hide or show the character early. The bench also confirms that cycles without a tick freeze the pattern, that the reset state shows everything, and that characters without the attribute are never hidden, even in a hidden phase.

// File: rtl/blink_pkg.sv
package blink_pkg;

    typedef enum logic [1:0] {
        DUTY_OFF  = 2'b00,
        DUTY_Q1   = 2'b01,
        DUTY_HALF = 2'b10,
        DUTY_Q3   = 2'b11
    } duty_e;

    typedef struct packed {
        logic  long_p;
        duty_e duty;
    } blink_cfg_t;

    // Visible ticks in a period of len ticks for duty code k (k quarters).
    function automatic int unsigned on_span(int unsigned len, int unsigned k);
        return (len * k) / 4;
    endfunction

endpackage

// File: rtl/blink_phase_ctr.sv
module blink_phase_ctr
    import blink_pkg::*;
#(
    parameter int unsigned SHORT_TICKS = 30,
    parameter int unsigned LONG_TICKS  = 60,
    parameter int unsigned PW          = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  blink_cfg_t       cfg_in,
    output blink_cfg_t       cfg_q,
    output logic [PW-1:0]    phase_q
);

    localparam logic [PW-1:0] LAST_SHORT = PW'(SHORT_TICKS - 1);
    localparam logic [PW-1:0] LAST_LONG  = PW'(LONG_TICKS - 1);

    typedef struct packed {
        blink_cfg_t    cfg;
        logic [PW-1:0] phase;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic [PW-1:0] last_w;
    logic boundary_w;

    always_comb begin
        st_d       = st_q;
        last_w     = st_q.cfg.long_p ? LAST_LONG : LAST_SHORT;
        boundary_w = tick && ((st_q.cfg.duty == DUTY_OFF) || (st_q.phase == last_w));
        if (boundary_w) begin
            st_d.phase = '0;
            st_d.cfg   = cfg_in;
        end else if (tick) begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_q   = st_q.cfg;
    assign phase_q = st_q.phase;

    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase <= (st_q.cfg.long_p ? LAST_LONG : LAST_SHORT)); // R6
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.phase == (st_q.cfg.long_p ? LAST_LONG : LAST_SHORT)) |=> (st_q.phase == '0)); // R7
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(st_q.phase) && $stable(st_q.cfg))); // R8
    AST_OFF_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.duty == DUTY_OFF) |-> (st_q.phase == '0)); // R2

endmodule

// File: rtl/blink_duty_cmp.sv
module blink_duty_cmp
    import blink_pkg::*;
#(
    parameter int unsigned SHORT_TICKS = 30,
    parameter int unsigned LONG_TICKS  = 60,
    parameter int unsigned PW          = 6
) (
    input  blink_cfg_t    cfg,
    input  logic [PW-1:0] phase,
    input  logic          attr,
    output logic          visible
);

    logic [PW-1:0] on_short [4];
    logic [PW-1:0] on_long  [4];
    logic [PW-1:0] on_w;

    for (genvar k = 0; k < 4; k++) begin : g_span
        assign on_short[k] = PW'(on_span(SHORT_TICKS, k));
        assign on_long[k]  = PW'(on_span(LONG_TICKS, k));
    end

    always_comb begin
        on_w    = cfg.long_p ? on_long[cfg.duty] : on_short[cfg.duty];
        visible = !attr || (cfg.duty == DUTY_OFF) || (phase < on_w);
    end

endmodule

// File: rtl/blink_attr_timer.sv
module blink_attr_timer
    import blink_pkg::*;
#(
    parameter int unsigned SHORT_TICKS = 30,
    parameter int unsigned LONG_TICKS  = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] blink_ctrl,
    input  logic       char_blink,
    output logic       char_visible
);

    localparam int unsigned MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int unsigned PW   = (MAXT > 2) ? $clog2(MAXT) : 1;

    blink_cfg_t    cfg_in_w, cfg_act_w;
    logic [PW-1:0] phase_w;

    assign cfg_in_w.long_p = blink_ctrl[2];
    assign cfg_in_w.duty   = duty_e'(blink_ctrl[1:0]);

    blink_phase_ctr #(
        .SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS), .PW(PW)
    ) u_ctr (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cfg_in(cfg_in_w), .cfg_q(cfg_act_w), .phase_q(phase_w)
    );

    blink_duty_cmp #(
        .SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS), .PW(PW)
    ) u_cmp (
        .cfg(cfg_act_w), .phase(phase_w), .attr(char_blink), .visible(char_visible)
    );

    AST_PLAIN_ALWAYS_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !char_blink |-> char_visible); // R1
    AST_START_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && blink_ctrl[1:0] != 2'b00 && cfg_act_w.duty == DUTY_OFF) |=> char_visible || !char_blink); // R8

endmodule

// File: tb/tb_blink_attr_timer.sv
module tb_blink_attr_timer;

    localparam int unsigned SHORT_T = 30;
    localparam int unsigned LONG_T  = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [2:0] blink_ctrl = 3'b000;
    logic char_blink = 1'b0;
    logic char_visible;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    blink_attr_timer #(.SHORT_TICKS(SHORT_T), .LONG_TICKS(LONG_T)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .blink_ctrl(blink_ctrl),
        .char_blink(char_blink), .char_visible(char_visible)
    );

    // {period bit, duty code}
    localparam logic [2:0] VEC [6] = '{3'b001, 3'b010, 3'b011, 3'b101, 3'b110, 3'b111};

    function automatic logic exp_vis(logic [2:0] c, int n);
        int p;
        int k;
        p = c[2] ? LONG_T : SHORT_T;
        k = int'(c[1:0]);
        if (k == 0) return 1'b1;
        return ((n % p) < (p * k) / 4);
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Vector walk: every period and duty, two full periods each
        for (int v = 0; v < 6; v++) begin
            string tag;
            int p;
            case (VEC[v][1:0])
                2'b01:   tag = "R3 R6 R7 quarter duty";
                2'b10:   tag = "R4 R6 R7 half duty";
                default: tag = "R5 R6 R7 three-quarter duty";
            endcase
            p = VEC[v][2] ? LONG_T : SHORT_T;
            do_reset();
            blink_ctrl = VEC[v];
            char_blink = 1'b1;
            pulse_tick(); // off -> load at this tick, phase 0
            for (int n = 0; n < 2 * p; n++) begin
                @(negedge clk);
                check(tag, char_visible, exp_vis(VEC[v], n));
                pulse_tick();
            end
        end

        // R9: reset state shows a blinking character before any tick
        do_reset();
        blink_ctrl = 3'b011;
        char_blink = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 reset visible", char_visible, 1'b1);

        // R2: duty off keeps blinking characters visible over many ticks
        blink_ctrl = 3'b100;
        for (int n = 0; n < 40; n++) begin
            pulse_tick();
            check("R2 duty off", char_visible, 1'b1);
        end

        // Load half duty short period; go to hidden phase 16
        blink_ctrl = 3'b010;
        pulse_tick(); // loaded, phase 0
        repeat (16) pulse_tick();
        check("R4 hidden at phase 16", char_visible, 1'b0);

        // R1: attribute clear shows character in a hidden phase
        char_blink = 1'b0;
        @(negedge clk);
        check("R1 no attribute", char_visible, 1'b1);
        char_blink = 1'b1;

        // R7: no tick for many cycles holds the hidden state
        repeat (50) @(negedge clk);
        check("R7 hold without tick", char_visible, 1'b0);

        // R8: switch input to off mid-period; old pattern stays until wrap
        blink_ctrl = 3'b000;
        repeat (13) pulse_tick(); // phase 29
        check("R8 old setting kept before wrap", char_visible, 1'b0);
        pulse_tick(); // wrap, off loaded
        check("R8 off active after wrap", char_visible, 1'b1);

        // R8: from off, a new setting loads at the very next tick
        blink_ctrl = 3'b001;
        @(negedge clk);
        check("R8 not loaded without tick", char_visible, 1'b1);
        pulse_tick(); // loaded, phase 0 visible
        repeat (7) pulse_tick(); // phase 7 hidden under quarter duty
        check("R8 quarter duty loaded", char_visible, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule